// File: doc/BRIEF.md
# Locality-Aware Pooled Section Allocator

This block hands out pieces of a shared memory pool that is cut into fixed 2 MB sections. Some sections are backed by memory that compute nodes lend to the pool, and the rest sit on remote memory devices. All of them share one fabric address space. The allocator keeps one busy bit and one fixed owner tag per section. It answers each request with a fabric base address, and it takes frees on a separate port that never stalls.

Two request flavours exist. A single-section request may be marked latency-sensitive, as for queue structures. Such a request goes first to a free section owned by the requesting node, and takes any free section only when the node has none left. A region request needs a block of `REGION_LEN` consecutive sections that starts on a multiple of `REGION_LEN`. The search looks at one section per clock, so every answer arrives within a known number of cycles.

Top module: `secpool_alloc`

## Requirements
- R1: After reset, every section is free, `req_ready` is high, `rsp_valid` is low and `dfree_err` is low.
- R2: A granted response carries `rsp_addr = cfg_pool_base + index * 2^21`, where index is the first section granted.
- R3: A latency-sensitive single request (`req_region`=0, `req_lat`=1) is given the lowest-indexed free section owned by `req_node`.
- R4: When the requesting node owns no free section, a latency-sensitive request is given the lowest-indexed free section of the whole pool.
- R5: A plain single request (`req_region`=0, `req_lat`=0) is given the lowest-indexed free section of the whole pool, whatever its owner.
- R6: A region request (`req_region`=1) is given the lowest block of `REGION_LEN` free sections whose first index is a multiple of `REGION_LEN`. All sections of that block become busy.
- R7: When nothing fits, the block answers with `rsp_valid`=1 and `rsp_ok`=0, and no section changes state.
- R8: A pulse on `free_valid` marks section `free_sect` free, and that section can be granted again.
- R9: Freeing a section that is already free sets `dfree_err` and leaves the busy map unchanged. The flag stays set until reset.
- R10: Only one request is in flight at a time. `req_ready` is low from acceptance until the response, and the response arrives at most 2*`N_SECT` cycles after acceptance.
- R11: Node n owns sections n*`SECT_PER_NODE` through (n+1)*`SECT_PER_NODE`-1 for n < `N_NODES`. Higher sections belong to remote devices and are owned by no node.
- R12: A free that arrives in the same cycle a request is accepted is already visible to that request's search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pool_base | input | ADDR_W | Fabric address of section 0 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Allocator idle, request taken when valid |
| req_region | input | 1 | 1: region request, 0: single section |
| req_lat | input | 1 | Latency-sensitive flag for single requests |
| req_node | input | NODE_W | Requesting node id |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | 1: granted, 0: no space |
| rsp_addr | output | ADDR_W | Fabric base address of the grant |
| free_valid | input | 1 | Free strobe |
| free_sect | input | IDX_W | Section index to free |
| dfree_err | output | 1 | Sticky double-free flag |

## Verification
Frees and the allocation search can land in the same clock. The bench provokes this in two ways. First, it drives `free_valid` in the very cycle a request is accepted, and expects the freed section to be granted by that request. Second, it lets frees retire while the busy map is heavily used, and then compares each grant against a reference map of the pool kept in the bench. A double free near a commit is judged by the flag and by the section's later grant order.

// File: rtl/secpool_pkg.sv
package secpool_pkg;

    // Section size is fixed at 2 MB: address = base + index << SECT_SHIFT
    localparam int SECT_SHIFT = 21;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,   // latency pass over the requester's own sections
        ST_ANY  = 2'd2,   // pass over every section
        ST_RGN  = 2'd3    // aligned block search
    } scan_st_e;

    // Owner map: compute-node sections lie low, grouped per node
    function automatic logic owned_by(int idx, int node, int per_node, int n_nodes);
        return (idx < per_node * n_nodes) && ((idx / per_node) == node);
    endfunction

endpackage

// File: rtl/secpool_map.sv
module secpool_map
    import secpool_pkg::*;
#(
    parameter int N_SECT = 16,
    localparam int IDX_W = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_valid,
    input  logic [IDX_W-1:0]  free_sect,
    input  logic [N_SECT-1:0] set_mask,
    output logic [N_SECT-1:0] busy,
    output logic              dfree_err
);

    logic [N_SECT-1:0] clr_mask;
    logic              dfree_now;

    always_comb begin
        clr_mask  = '0;
        if (free_valid) clr_mask[free_sect] = 1'b1;
        dfree_now = free_valid && !busy[free_sect];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= '0;
            dfree_err <= 1'b0;
        end else begin
            busy <= (busy & ~clr_mask) | set_mask;
            if (dfree_now) dfree_err <= 1'b1;
        end
    end

    // R7: a commit never claims a section that is already taken
    p_no_regrant_r7: assert property (@(posedge clk) disable iff (rst)
        (set_mask & busy) == '0);

    // R9: the flag is sticky
    p_sticky_err_r9: assert property (@(posedge clk) disable iff (rst)
        dfree_err |=> dfree_err);

    // R9: a double free does not mark the section busy
    p_dfree_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (free_valid && !busy[free_sect] && set_mask == '0) |=> busy == $past(busy));

endmodule

// File: rtl/secpool_scan.sv
module secpool_scan
    import secpool_pkg::*;
#(
    parameter int N_SECT        = 16,
    parameter int N_NODES       = 2,
    parameter int SECT_PER_NODE = 4,
    parameter int REGION_LEN    = 4,
    parameter int NODE_W        = 2,
    localparam int IDX_W = $clog2(N_SECT),
    localparam int CNT_W = $clog2(REGION_LEN + 1),
    localparam int CYC_W = $clog2(2 * N_SECT + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_region,
    input  logic              req_lat,
    input  logic [NODE_W-1:0] req_node,
    input  logic [N_SECT-1:0] busy,
    output logic [N_SECT-1:0] set_mask,
    output logic              hit_valid,
    output logic              hit_ok,
    output logic [IDX_W-1:0]  hit_idx
);

    scan_st_e          state;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  run_cnt;
    logic [NODE_W-1:0] node_q;
    logic              rgn_q;
    logic [N_SECT-1:0] own_vec;

    logic              sect_free;
    logic              last_idx;
    logic              blk_first;
    logic [CNT_W-1:0]  run_nx;
    logic              hit;
    logic [IDX_W-1:0]  base_idx;

    // Ownership of each section relative to the latched requester
    for (genvar g = 0; g < N_SECT; g++) begin : g_own
        assign own_vec[g] = owned_by(g, int'(node_q), SECT_PER_NODE, N_NODES);
    end

    assign req_ready = (state == ST_IDLE);

    always_comb begin
        sect_free = !busy[idx];
        last_idx  = (idx == IDX_W'(N_SECT - 1));
        blk_first = ((int'(idx) % REGION_LEN) == 0);
        if (!sect_free)     run_nx = '0;
        else if (blk_first) run_nx = CNT_W'(1);
        else                run_nx = run_cnt + CNT_W'(1);

        unique case (state)
            ST_OWN:  hit = sect_free && own_vec[idx];
            ST_ANY:  hit = sect_free;
            ST_RGN:  hit = (run_nx == CNT_W'(REGION_LEN));
            default: hit = 1'b0;
        endcase

        base_idx = (state == ST_RGN) ? idx - IDX_W'(REGION_LEN - 1) : idx;

        set_mask = '0;
        if (hit) begin
            for (int i = 0; i < N_SECT; i++) begin
                if (i >= int'(base_idx) && i <= int'(idx)) set_mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx       <= '0;
            run_cnt   <= '0;
            node_q    <= '0;
            rgn_q     <= 1'b0;
            hit_valid <= 1'b0;
            hit_ok    <= 1'b0;
            hit_idx   <= '0;
        end else begin
            hit_valid <= 1'b0;
            if (state == ST_IDLE) begin
                if (req_valid) begin
                    idx     <= '0;
                    run_cnt <= '0;
                    node_q  <= req_node;
                    rgn_q   <= req_region;
                    if (req_region)   state <= ST_RGN;
                    else if (req_lat) state <= ST_OWN;
                    else              state <= ST_ANY;
                end
            end else begin
                run_cnt <= run_nx;
                if (hit) begin
                    hit_valid <= 1'b1;
                    hit_ok    <= 1'b1;
                    hit_idx   <= base_idx;
                    state     <= ST_IDLE;
                end else if (last_idx) begin
                    if (state == ST_OWN) begin
                        state   <= ST_ANY;
                        idx     <= '0;
                    end else begin
                        hit_valid <= 1'b1;
                        hit_ok    <= 1'b0;
                        state     <= ST_IDLE;
                    end
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // Checker state: cycles spent searching
    logic [CYC_W-1:0] scan_cyc;
    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) scan_cyc <= '0;
        else                         scan_cyc <= scan_cyc + CYC_W'(1);
    end

    // R10: search finishes within two passes
    p_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (int'(scan_cyc) < 2 * N_SECT));

    // R6: region grants start on an aligned boundary
    p_align_r6: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && hit_ok && rgn_q) |-> ((int'(hit_idx) % REGION_LEN) == 0));

    // R3: a grant in the own-section pass lands on an owned section
    p_own_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OWN && set_mask != '0) |-> ((set_mask & ~own_vec) == '0));

endmodule

// File: rtl/secpool_alloc.sv
module secpool_alloc
    import secpool_pkg::*;
#(
    parameter int N_SECT        = 16,
    parameter int N_NODES       = 2,
    parameter int SECT_PER_NODE = 4,
    parameter int REGION_LEN    = 4,
    parameter int NODE_W        = 2,
    parameter int ADDR_W        = 48,
    localparam int IDX_W = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_pool_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_region,
    input  logic              req_lat,
    input  logic [NODE_W-1:0] req_node,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [ADDR_W-1:0] rsp_addr,
    input  logic              free_valid,
    input  logic [IDX_W-1:0]  free_sect,
    output logic              dfree_err
);

    logic [N_SECT-1:0] busy;
    logic [N_SECT-1:0] set_mask;
    logic [IDX_W-1:0]  hit_idx;

    secpool_map #(.N_SECT(N_SECT)) u_map (
        .clk        (clk),
        .rst        (rst),
        .free_valid (free_valid),
        .free_sect  (free_sect),
        .set_mask   (set_mask),
        .busy       (busy),
        .dfree_err  (dfree_err)
    );

    secpool_scan #(
        .N_SECT        (N_SECT),
        .N_NODES       (N_NODES),
        .SECT_PER_NODE (SECT_PER_NODE),
        .REGION_LEN    (REGION_LEN),
        .NODE_W        (NODE_W)
    ) u_scan (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_region (req_region),
        .req_lat    (req_lat),
        .req_node   (req_node),
        .busy       (busy),
        .set_mask   (set_mask),
        .hit_valid  (rsp_valid),
        .hit_ok     (rsp_ok),
        .hit_idx    (hit_idx)
    );

    assign rsp_addr = cfg_pool_base + (ADDR_W'(hit_idx) << SECT_SHIFT);

    // R2: a granted address is section aligned relative to the base
    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ok) |-> ((rsp_addr - cfg_pool_base) & ((ADDR_W'(1) << SECT_SHIFT) - 1)) == '0);

endmodule

// File: tb/secpool_alloc_tb_top.sv
module secpool_alloc_tb_top;

    localparam int N_SECT = 16;
    localparam int N_NODES = 2;
    localparam int SPN = 4;
    localparam int RLEN = 4;
    localparam int NODE_W = 2;
    localparam int ADDR_W = 48;
    localparam int IDX_W = $clog2(N_SECT);
    localparam logic [ADDR_W-1:0] BASE = 48'h0012_3400_0000;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic              rst;
    logic              req_valid, req_ready, req_region, req_lat;
    logic [NODE_W-1:0] req_node;
    logic              rsp_valid, rsp_ok;
    logic [ADDR_W-1:0] rsp_addr;
    logic              free_valid;
    logic [IDX_W-1:0]  free_sect;
    logic              dfree_err;

    secpool_alloc #(
        .N_SECT(N_SECT), .N_NODES(N_NODES), .SECT_PER_NODE(SPN),
        .REGION_LEN(RLEN), .NODE_W(NODE_W), .ADDR_W(ADDR_W)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_pool_base(BASE),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_region(req_region), .req_lat(req_lat), .req_node(req_node),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_addr(rsp_addr),
        .free_valid(free_valid), .free_sect(free_sect), .dfree_err(dfree_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic [N_SECT-1:0] mbusy = '0;
    logic exp_err = 1'b0;

    task automatic check(input logic ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic owns(int i, int node);
        return (i < SPN * N_NODES) && (i / SPN == node);
    endfunction

    function automatic int exp_single(logic lat, int node);
        if (lat)
            for (int i = 0; i < N_SECT; i++) if (!mbusy[i] && owns(i, node)) return i;
        for (int i = 0; i < N_SECT; i++) if (!mbusy[i]) return i;
        return -1;
    endfunction

    function automatic int exp_region();
        for (int b = 0; b < N_SECT; b += RLEN) begin
            logic all_free = 1'b1;
            for (int j = 0; j < RLEN; j++) if (mbusy[b + j]) all_free = 1'b0;
            if (all_free) return b;
        end
        return -1;
    endfunction

    // One request, optionally with a free in the acceptance cycle (R12)
    task automatic do_req(input logic region, input logic lat, input int node,
                          input logic fr_en, input int fr_idx, input string tag);
        int exp_i, k;
        @(negedge clk);
        req_valid = 1'b1; req_region = region; req_lat = lat; req_node = NODE_W'(node);
        free_valid = fr_en; free_sect = IDX_W'(fr_idx);
        if (fr_en) begin
            if (!mbusy[fr_idx]) exp_err = 1'b1;
            mbusy[fr_idx] = 1'b0;
        end
        exp_i = region ? exp_region() : exp_single(lat, node);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; free_valid = 1'b0;
        check(req_ready == 1'b0, tag, "R10 ready low while searching", req_ready, 0);
        k = 0;
        while (k < 4 * N_SECT) begin
            @(posedge clk);
            @(negedge clk);
            k++;
            if (rsp_valid) break;
        end
        check(rsp_valid == 1'b1 && k <= 2 * N_SECT, tag, "R10 response cycles", k, 2 * N_SECT);
        check(rsp_ok == (exp_i >= 0), tag, "R7 ok flag", rsp_ok, exp_i >= 0);
        if (exp_i >= 0) begin
            check(rsp_addr == BASE + (ADDR_W'(exp_i) << 21), tag, "R2 address",
                  rsp_addr, BASE + (ADDR_W'(exp_i) << 21));
            for (int j = 0; j < (region ? RLEN : 1); j++) mbusy[exp_i + j] = 1'b1;
        end
        check(req_ready == 1'b1, tag, "R10 ready back", req_ready, 1);
    endtask

    task automatic do_free(input int idx, input string tag);
        @(negedge clk);
        free_valid = 1'b1; free_sect = IDX_W'(idx);
        if (!mbusy[idx]) exp_err = 1'b1;
        mbusy[idx] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        free_valid = 1'b0;
        check(dfree_err == exp_err, tag, "R9 error flag", dfree_err, exp_err);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 0; req_region = 0; req_lat = 0; req_node = 0;
        free_valid = 0; free_sect = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rsp_valid == 1'b0, "R1", "no response", rsp_valid, 0);
        check(dfree_err == 1'b0, "R1", "flag clear", dfree_err, 0);
    endtask

    task automatic t_locality();
        do_req(0, 1, 1, 0, 0, "R3 lat node1 own first");    // -> 4 (R11 map)
        do_req(0, 0, 1, 0, 0, "R5 plain lowest");           // -> 0
        for (int i = 0; i < 3; i++) do_req(0, 1, 1, 0, 0, "R3 lat node1 fill");
        do_req(0, 1, 1, 0, 0, "R4 fallback to pool");       // -> 1
    endtask

    task automatic t_regions();
        do_req(1, 0, 0, 0, 0, "R6 region first block");     // -> 8
        do_req(1, 0, 0, 0, 0, "R6 region next block");      // -> 12
        do_req(1, 0, 0, 0, 0, "R7 region none fits");       // fail
        do_req(0, 0, 0, 0, 0, "R7 map unchanged after fail");   // -> 2
        do_req(0, 1, 0, 0, 0, "R11 node0 owns section 3");  // -> 3
        do_req(0, 0, 0, 0, 0, "R7 pool full");              // fail
    endtask

    task automatic t_free_reuse();
        do_free(5, "R8 free busy section");
        do_req(0, 1, 0, 0, 0, "R8 freed section reused R4");    // -> 5
    endtask

    task automatic t_double_free();
        do_free(9, "R8 free 9");
        do_free(9, "R9 double free");
        do_req(0, 0, 0, 0, 0, "R9 map unchanged");          // -> 9
        do_free(6, "R9 flag sticky over good free");
    endtask

    task automatic t_same_cycle();
        do_req(0, 1, 0, 1, 0, "R12 free at accept");        // -> 0
        for (int i = 12; i < 16; i++) do_free(i, "R8 free block");
        do_free(8, "R8 free 8");
        do_req(1, 0, 0, 0, 0, "R6 aligned run after frees");    // -> 12
    endtask

    initial begin
        t_reset();
        t_locality();
        t_regions();
        t_free_reuse();
        t_double_free();
        t_same_cycle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule